// File: doc/BRIEF.md
# Serial ATA Feature Capability and Enable Registers

This block keeps the three Serial ATA words a device reports when it is identified: the capability word at index 76 (signalling rates, host-initiated power states, Phy event counters, queued-command availability), the supported-feature word at index 78 and the enabled-feature word at index 79. Index 77 is reserved and reads zero. The live enable state behind word 79 is kept here. A command decoder or firmware turns single features on or off through a small control port. A configuration-overlay pair of inputs can withdraw queued-command support and non-zero buffer offset support, and a mode pin applies packet-device rules, which reserve the queuing-related bits.

A link-reset (COMRESET) input either keeps the software-set enables or returns them to their power-on defaults, depending on the settings-preservation enable. A command-check path raises an abort for a queued read or write when queuing is unavailable, and it records ERR and ABRT. An outgoing DMA buffer-offset field is forced to zero unless non-zero offsets are enabled. Any word is read combinationally by its 8-bit index.

The enable state is kept by a three-state machine. `ST_POR` is the first cycle after power-on and loads the defaults. `ST_RUN` is normal operation. `ST_LINKRST` is entered while COMRESET is held. The transitions are: `ST_POR` to `ST_RUN` (COMRESET low) or to `ST_LINKRST` (COMRESET high); `ST_RUN` to `ST_LINKRST` when COMRESET is sampled high; `ST_LINKRST` back to `ST_RUN` when COMRESET falls; otherwise each state holds.

Top module: `sfeat_ident_regs`

## Requirements
- R1: Word 76 equals the capability mask restricted to bit 1 (1.5 Gbps), bit 2 (3.0 Gbps), bit 9 (host-initiated Partial/Slumber) and bit 10 (Phy event counters). Both rate bits may be set together. Bit 8 (queuing) reads one only in non-packet mode with overlay queuing allowed and mask bit 8 set. Every other bit, bit 0 included, reads zero.
- R2: Index 77 reads zero. Bits 0 and 7 to 15 of words 78 and 79 read zero. Any index outside 76 to 79 reads zero.
- R3: With `pkt_mode`=1, bits 1, 2 and 4 of words 78 and 79 read zero and both overlay inputs have no effect.
- R4: In non-packet mode with `ovl_nzo`=0, bits 1 and 4 of words 78 and 79 read zero and `dma_off_out` is zero.
- R5: In non-packet mode with `ovl_ncq`=0, word 76 bit 8 and bits 1, 2 and 4 of words 78 and 79 read zero.
- R6: From reset, word 79 reads zero during `ST_POR`. After the first clock, bits 1 to 5 of word 79 are zero and bit 6 equals word 78 bit 6.
- R7: A control request (`ctl_sel` = bit 1..6, `ctl_set`=1 enable, 0 disable) in `ST_RUN` changes that bit of word 79 at the next edge. Setting a bit whose word-78 bit is zero is ignored. Selections 0 and 7 are ignored.
- R8: COMRESET sampled high in `ST_RUN` keeps all enables if word 79 bit 6 is one. Otherwise it restores the R6 defaults at that edge. Control requests are ignored while COMRESET stays high.
- R9: Word 79 never shows a bit that word 78 lacks. An enable lost because support was withdrawn stays zero when the support returns.
- R10: With `cmd_valid`=1 and `cmd_queued`=1 while word 76 bit 8 would read zero, `cmd_abort` is one in the same cycle, and at the next edge `ata_status` bit 0 (ERR) and `ata_error` bit 2 (ABRT) become one. Any other valid command clears both registers.
- R11: `dma_off_out` equals `dma_off_in` when word 79 bit 1 is one, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pkt_mode | input | 1 | 1 = packet-device rules |
| cap_mask | input | 16 | Capabilities the device implements (word 76 positions) |
| feat_mask | input | 16 | Optional features implemented (word 78 positions) |
| ovl_ncq | input | 1 | Overlay: queued commands allowed |
| ovl_nzo | input | 1 | Overlay: non-zero buffer offsets allowed |
| comreset | input | 1 | Link reset indication |
| ctl_valid | input | 1 | Feature control request |
| ctl_set | input | 1 | 1 = enable, 0 = disable |
| ctl_sel | input | 3 | Bit of word 79 addressed |
| rd_idx | input | 8 | Word index to read |
| rd_data | output | 16 | Word read (combinational) |
| cmd_valid | input | 1 | Command presented for checking |
| cmd_queued | input | 1 | Command is a queued read or write |
| cmd_abort | output | 1 | Command must be aborted |
| ata_status | output | 8 | Status register, bit 0 = ERR |
| ata_error | output | 8 | Error register, bit 2 = ABRT |
| dma_off_in | input | 32 | Buffer offset requested for a DMA setup |
| dma_off_out | output | 32 | Buffer offset sent |

## Verification
The hardest case is the interaction between the enable state and support that changes under it. An enable is set, then withdrawn through the overlay or packet mode, then restored. This must happen around COMRESET pulses both with and without the preservation bit. Directed sequences build each of these orders explicitly. A long seeded random run then toggles overlay, mode, masks, COMRESET and control requests at uneven rates, so that link resets land on requests and on support changes while a bench model predicts every read.

// File: rtl/sfeat_pkg.sv
package sfeat_pkg;
    localparam int WORD_W = 16;

    // word 76 positions
    localparam int B_GEN1  = 1;
    localparam int B_GEN2  = 2;
    localparam int B_NCQ   = 8;
    localparam int B_HIPM  = 9;
    localparam int B_PHYEV = 10;

    // word 78/79 positions
    localparam int F_NZO      = 1;
    localparam int F_AUTOACT  = 2;
    localparam int F_DIPM     = 3;
    localparam int F_INORDER  = 4;
    localparam int F_ASYNC    = 5;
    localparam int F_PRESERVE = 6;

    localparam logic [WORD_W-1:0] CAP_LEGAL =
        (WORD_W'(1) << B_GEN1) | (WORD_W'(1) << B_GEN2) | (WORD_W'(1) << B_NCQ) |
        (WORD_W'(1) << B_HIPM) | (WORD_W'(1) << B_PHYEV);
    localparam logic [WORD_W-1:0] FEAT_LEGAL =
        (WORD_W'(1) << F_NZO) | (WORD_W'(1) << F_AUTOACT) | (WORD_W'(1) << F_DIPM) |
        (WORD_W'(1) << F_INORDER) | (WORD_W'(1) << F_ASYNC) | (WORD_W'(1) << F_PRESERVE);
    localparam logic [WORD_W-1:0] DEP_NZO =
        (WORD_W'(1) << F_NZO) | (WORD_W'(1) << F_INORDER);
    localparam logic [WORD_W-1:0] DEP_NCQ = DEP_NZO | (WORD_W'(1) << F_AUTOACT);
    localparam logic [WORD_W-1:0] PKT_RSVD = DEP_NCQ;
    localparam logic [WORD_W-1:0] DEF_MASK = WORD_W'(1) << F_PRESERVE;

    localparam int STS_ERR  = 0;
    localparam int ERR_ABRT = 2;

    typedef enum logic [1:0] {
        ST_POR     = 2'd0,
        ST_RUN     = 2'd1,
        ST_LINKRST = 2'd2
    } en_state_t;
endpackage

// File: rtl/sfeat_support.sv
module sfeat_support
    import sfeat_pkg::*;
(
    input  logic              pkt_mode,
    input  logic              ovl_ncq,
    input  logic              ovl_nzo,
    input  logic [WORD_W-1:0] cap_mask,
    input  logic [WORD_W-1:0] feat_mask,
    output logic [WORD_W-1:0] cap_word,
    output logic [WORD_W-1:0] sup_word,
    output logic              ncq_ok
);
    always_comb begin
        ncq_ok           = !pkt_mode && ovl_ncq && cap_mask[B_NCQ];
        cap_word         = cap_mask & CAP_LEGAL;
        cap_word[B_NCQ]  = ncq_ok;

        sup_word = feat_mask & FEAT_LEGAL;
        if (pkt_mode) begin
            sup_word = sup_word & ~PKT_RSVD;
        end else begin
            if (!ovl_ncq) sup_word = sup_word & ~DEP_NCQ;
            if (!ovl_nzo) sup_word = sup_word & ~DEP_NZO;
        end
    end
endmodule

// File: rtl/sfeat_enable_fsm.sv
module sfeat_enable_fsm
    import sfeat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              comreset,
    input  logic              ctl_valid,
    input  logic              ctl_set,
    input  logic [2:0]        ctl_sel,
    input  logic [WORD_W-1:0] sup_word,
    output logic [WORD_W-1:0] en_word,
    output en_state_t         state_o
);
    en_state_t         state_q, state_d;
    logic [WORD_W-1:0] en_q, en_d, def_word;
    logic              sel_ok;

    assign def_word = sup_word & DEF_MASK;
    assign en_word  = en_q & sup_word;
    assign sel_ok   = (ctl_sel != 3'd0) && (ctl_sel != 3'd7);
    assign state_o  = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POR;
            en_q    <= '0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR:     state_d = comreset ? ST_LINKRST : ST_RUN;
            ST_RUN:     state_d = comreset ? ST_LINKRST : ST_RUN;
            ST_LINKRST: state_d = comreset ? ST_LINKRST : ST_RUN;
            default:    state_d = ST_POR;
        endcase
    end

    // enable state update
    always_comb begin
        en_d = en_q;
        unique case (state_q)
            ST_POR: en_d = def_word;
            ST_RUN: begin
                if (comreset) begin
                    if (!en_word[F_PRESERVE]) en_d = def_word;
                end else if (ctl_valid && sel_ok) begin
                    en_d[{1'b0, ctl_sel}] = ctl_set;
                end
            end
            ST_LINKRST: en_d = en_q;
            default:    en_d = '0;
        endcase
        en_d = en_d & sup_word;
    end
endmodule

// File: rtl/sfeat_cmd_check.sv
module sfeat_cmd_check
    import sfeat_pkg::*;
#(
    parameter int OFF_W = 32,
    parameter int ST_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_queued,
    input  logic             ncq_ok,
    input  logic             nzo_en,
    input  logic [OFF_W-1:0] off_in,
    output logic             abort,
    output logic [ST_W-1:0]  status,
    output logic [ST_W-1:0]  error,
    output logic [OFF_W-1:0] off_out
);
    assign abort   = cmd_valid && cmd_queued && !ncq_ok;
    assign off_out = nzo_en ? off_in : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            error  <= '0;
        end else if (cmd_valid) begin
            status <= '0;
            error  <= '0;
            status[STS_ERR] <= abort;
            error[ERR_ABRT] <= abort;
        end
    end
endmodule

// File: rtl/sfeat_read_mux.sv
module sfeat_read_mux
    import sfeat_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int BASE_IDX = 76
) (
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] cap_word,
    input  logic [WORD_W-1:0] sup_word,
    input  logic [WORD_W-1:0] en_word,
    output logic [WORD_W-1:0] rd_data
);
    localparam logic [IDX_W-1:0] I_CAP = IDX_W'(BASE_IDX);
    localparam logic [IDX_W-1:0] I_SUP = IDX_W'(BASE_IDX + 2);
    localparam logic [IDX_W-1:0] I_EN  = IDX_W'(BASE_IDX + 3);

    always_comb begin
        rd_data = '0;
        if (rd_idx == I_CAP)      rd_data = cap_word;
        else if (rd_idx == I_SUP) rd_data = sup_word;
        else if (rd_idx == I_EN)  rd_data = en_word;
    end
endmodule

// File: rtl/sfeat_ident_regs.sv
module sfeat_ident_regs
    import sfeat_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int BASE_IDX = 76,
    parameter int OFF_W    = 32,
    parameter int ST_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_mode,
    input  logic [15:0]      cap_mask,
    input  logic [15:0]      feat_mask,
    input  logic             ovl_ncq,
    input  logic             ovl_nzo,
    input  logic             comreset,
    input  logic             ctl_valid,
    input  logic             ctl_set,
    input  logic [2:0]       ctl_sel,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_data,
    input  logic             cmd_valid,
    input  logic             cmd_queued,
    output logic             cmd_abort,
    output logic [ST_W-1:0]  ata_status,
    output logic [ST_W-1:0]  ata_error,
    input  logic [OFF_W-1:0] dma_off_in,
    output logic [OFF_W-1:0] dma_off_out
);
    logic [WORD_W-1:0] cap_word, sup_word, en_word;
    logic              ncq_ok;
    en_state_t         en_state;

    sfeat_support u_support (
        .pkt_mode (pkt_mode),
        .ovl_ncq  (ovl_ncq),
        .ovl_nzo  (ovl_nzo),
        .cap_mask (cap_mask),
        .feat_mask(feat_mask),
        .cap_word (cap_word),
        .sup_word (sup_word),
        .ncq_ok   (ncq_ok)
    );

    sfeat_enable_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .comreset (comreset),
        .ctl_valid(ctl_valid),
        .ctl_set  (ctl_set),
        .ctl_sel  (ctl_sel),
        .sup_word (sup_word),
        .en_word  (en_word),
        .state_o  (en_state)
    );

    sfeat_cmd_check #(.OFF_W(OFF_W), .ST_W(ST_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_queued(cmd_queued),
        .ncq_ok    (ncq_ok),
        .nzo_en    (en_word[F_NZO]),
        .off_in    (dma_off_in),
        .abort     (cmd_abort),
        .status    (ata_status),
        .error     (ata_error),
        .off_out   (dma_off_out)
    );

    sfeat_read_mux #(.IDX_W(IDX_W), .BASE_IDX(BASE_IDX)) u_rd (
        .rd_idx  (rd_idx),
        .cap_word(cap_word),
        .sup_word(sup_word),
        .en_word (en_word),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/sfeat_checker.sv
module sfeat_checker
    import sfeat_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int BASE_IDX = 76,
    parameter int OFF_W    = 32,
    parameter int ST_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_mode,
    input logic              ovl_nzo,
    input logic              comreset,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [WORD_W-1:0] rd_data,
    input logic [WORD_W-1:0] sup_word,
    input logic [WORD_W-1:0] en_word,
    input en_state_t         en_state,
    input logic              cmd_abort,
    input logic [ST_W-1:0]   ata_status,
    input logic [ST_W-1:0]   ata_error,
    input logic [OFF_W-1:0]  dma_off_out
);
    assert_rsvd_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IDX_W'(BASE_IDX + 1)) |-> (rd_data == '0));

    assert_pkt_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_mode |-> (((sup_word | en_word) & PKT_RSVD) == '0));

    assert_nzo_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_mode && !ovl_nzo) |-> (dma_off_out == '0));

    assert_por_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_state == ST_POR) |=> ((en_word & (FEAT_LEGAL & ~DEF_MASK)) == '0));

    assert_preserve_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_state == ST_RUN && comreset && en_word[F_PRESERVE])
        |=> (en_word == ($past(en_word) & sup_word)));

    assert_en_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_word & ~sup_word) == '0));

    assert_abort_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |=> (ata_status[STS_ERR] && ata_error[ERR_ABRT]));
endmodule

bind sfeat_ident_regs sfeat_checker #(
    .IDX_W(IDX_W), .BASE_IDX(BASE_IDX), .OFF_W(OFF_W), .ST_W(ST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_mode   (pkt_mode),
    .ovl_nzo    (ovl_nzo),
    .comreset   (comreset),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .sup_word   (sup_word),
    .en_word    (en_word),
    .en_state   (en_state),
    .cmd_abort  (cmd_abort),
    .ata_status (ata_status),
    .ata_error  (ata_error),
    .dma_off_out(dma_off_out)
);

// File: tb/sfeat_ident_regs_tb.sv
module sfeat_ident_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_mode = 1'b0;
    logic [15:0] cap_mask = 16'hFFFF;
    logic [15:0] feat_mask = 16'hFFFF;
    logic        ovl_ncq = 1'b1;
    logic        ovl_nzo = 1'b1;
    logic        comreset = 1'b0;
    logic        ctl_valid = 1'b0;
    logic        ctl_set = 1'b0;
    logic [2:0]  ctl_sel = 3'd0;
    logic [7:0]  rd_idx = 8'd79;
    logic [15:0] rd_data;
    logic        cmd_valid = 1'b0;
    logic        cmd_queued = 1'b0;
    logic        cmd_abort;
    logic [7:0]  ata_status, ata_error;
    logic [31:0] dma_off_in = 32'h0;
    logic [31:0] dma_off_out;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R6";

    // bench model
    logic [15:0] m_en = 16'h0;
    int          m_state = 0; // 0 power-on, 1 run, 2 link reset
    logic [7:0]  m_sts = 8'h0, m_err = 8'h0;

    always #5 clk = ~clk;

    sfeat_ident_regs u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_mode(pkt_mode), .cap_mask(cap_mask),
        .feat_mask(feat_mask), .ovl_ncq(ovl_ncq), .ovl_nzo(ovl_nzo),
        .comreset(comreset), .ctl_valid(ctl_valid), .ctl_set(ctl_set),
        .ctl_sel(ctl_sel), .rd_idx(rd_idx), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_queued(cmd_queued), .cmd_abort(cmd_abort),
        .ata_status(ata_status), .ata_error(ata_error),
        .dma_off_in(dma_off_in), .dma_off_out(dma_off_out)
    );

    function automatic logic f_ncq_ok();
        return !pkt_mode && ovl_ncq && cap_mask[8];
    endfunction

    function automatic logic [15:0] f_cap();
        logic [15:0] w;
        w = cap_mask & 16'h0606;
        w[8] = f_ncq_ok();
        return w;
    endfunction

    function automatic logic [15:0] f_sup();
        logic [15:0] w;
        w = feat_mask & 16'h007E;
        if (pkt_mode) w = w & ~16'h0016;
        else begin
            if (!ovl_ncq) w = w & ~16'h0016;
            if (!ovl_nzo) w = w & ~16'h0012;
        end
        return w;
    endfunction

    function automatic logic [15:0] f_read(input logic [7:0] idx);
        case (idx)
            8'd76:   return f_cap();
            8'd78:   return f_sup();
            8'd79:   return m_en & f_sup();
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_update();
        logic [15:0] sup, enw, def, nen;
        logic        ab;
        sup = f_sup();
        enw = m_en & sup;
        def = sup & 16'h0040;
        nen = m_en;
        case (m_state)
            0: begin nen = def; m_state = comreset ? 2 : 1; end
            1: begin
                if (comreset) begin
                    if (!enw[6]) nen = def;
                    m_state = 2;
                end else if (ctl_valid && ctl_sel != 3'd0 && ctl_sel != 3'd7) begin
                    nen[ctl_sel] = ctl_set;
                end
            end
            default: m_state = comreset ? 2 : 1;
        endcase
        m_en = nen & sup;
        if (cmd_valid) begin
            ab = cmd_queued && !f_ncq_ok();
            m_sts = ab ? 8'h01 : 8'h00;
            m_err = ab ? 8'h04 : 8'h00;
        end
    endtask

    // compare all outputs, then advance one clock (called just after a negedge)
    task automatic step();
        #1;
        chk(cur_req, "rd_data", {16'h0, rd_data}, {16'h0, f_read(rd_idx)});
        chk("R10", "cmd_abort", {31'h0, cmd_abort},
            {31'h0, cmd_valid && cmd_queued && !f_ncq_ok()});
        chk("R11", "dma_off_out", dma_off_out,
            (m_en[1] && f_sup()[1]) ? dma_off_in : 32'h0);
        chk("R10", "ata_status", {24'h0, ata_status}, {24'h0, m_sts});
        chk("R10", "ata_error", {24'h0, ata_error}, {24'h0, m_err});
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic rdchk(input string req, input logic [7:0] idx, input logic [15:0] exp);
        rd_idx = idx;
        #1;
        chk(req, $sformatf("word %0d", idx), {16'h0, rd_data}, {16'h0, exp});
    endtask

    task automatic ctl(input logic set, input logic [2:0] sel);
        ctl_valid = 1'b1; ctl_set = set; ctl_sel = sel;
        step();
        ctl_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // reset state (R6, R10)
        rdchk("R6", 8'd79, 16'h0000);
        chk("R10", "status in reset", {24'h0, ata_status}, 32'h0);
        rst_n = 1'b1;
        rdchk("R6", 8'd79, 16'h0000);
        step();
        // composition after defaults
        rdchk("R1", 8'd76, 16'h0706);
        rdchk("R2", 8'd77, 16'h0000);
        rdchk("R2", 8'd78, 16'h007E);
        rdchk("R6", 8'd79, 16'h0040);
        rdchk("R2", 8'd80, 16'h0000);
        rdchk("R2", 8'd75, 16'h0000);
        rdchk("R2", 8'd0,  16'h0000);
        rdchk("R2", 8'd255, 16'h0000);
        cap_mask = 16'h0002;
        rdchk("R1", 8'd76, 16'h0002);
        cap_mask = 16'hFFFF;

        // enable requests
        cur_req = "R7";
        for (int i = 1; i <= 5; i++) ctl(1'b1, 3'(i));
        rdchk("R7", 8'd79, 16'h007E);
        ctl(1'b1, 3'd0);
        ctl(1'b1, 3'd7);
        rdchk("R7", 8'd79, 16'h007E);
        feat_mask = 16'hFFDF;
        ctl(1'b0, 3'd5);
        ctl(1'b1, 3'd5);
        rdchk("R7", 8'd79, 16'h005E);
        feat_mask = 16'hFFFF;

        // offset gating
        dma_off_in = 32'hDEADBEEF;
        #1 chk("R11", "offset passed", dma_off_out, 32'hDEADBEEF);
        ctl(1'b0, 3'd1);
        #1 chk("R11", "offset zeroed", dma_off_out, 32'h0);
        rdchk("R7", 8'd79, 16'h005C);

        // link reset with preservation
        cur_req = "R8";
        comreset = 1'b1;
        step();
        ctl(1'b1, 3'd1);
        comreset = 1'b0;
        step();
        rdchk("R8", 8'd79, 16'h005C);
        ctl(1'b0, 3'd6);
        comreset = 1'b1; step(); comreset = 1'b0; step();
        rdchk("R8", 8'd79, 16'h0040);

        // packet mode
        cur_req = "R3";
        ctl(1'b1, 3'd1); ctl(1'b1, 3'd2); ctl(1'b1, 3'd4);
        rdchk("R3", 8'd79, 16'h0056);
        pkt_mode = 1'b1; ovl_ncq = 1'b0; ovl_nzo = 1'b0;
        rdchk("R3", 8'd78, 16'h0068);
        rdchk("R3", 8'd79, 16'h0040);
        rdchk("R3", 8'd76, 16'h0606);
        ovl_ncq = 1'b1; ovl_nzo = 1'b1;
        rdchk("R3", 8'd78, 16'h0068);
        step();
        pkt_mode = 1'b0;
        cur_req = "R9";
        step();
        rdchk("R9", 8'd79, 16'h0040);

        // overlay stripping
        cur_req = "R4";
        ctl(1'b1, 3'd1); ctl(1'b1, 3'd4);
        ovl_nzo = 1'b0;
        rdchk("R4", 8'd78, 16'h006C);
        rdchk("R4", 8'd79, 16'h0040);
        #1 chk("R4", "offset stripped", dma_off_out, 32'h0);
        step();
        ovl_nzo = 1'b1;
        cur_req = "R5";
        ovl_ncq = 1'b0;
        rdchk("R5", 8'd78, 16'h0068);
        rdchk("R5", 8'd76, 16'h0606);

        // queued command abort
        cmd_valid = 1'b1; cmd_queued = 1'b1;
        #1 chk("R10", "abort", {31'h0, cmd_abort}, 32'h1);
        step();
        chk("R10", "ERR", {24'h0, ata_status}, 32'h01);
        chk("R10", "ABRT", {24'h0, ata_error}, 32'h04);
        ovl_ncq = 1'b1;
        step();
        chk("R10", "ERR cleared", {24'h0, ata_status}, 32'h00);
        cmd_valid = 1'b0; cmd_queued = 1'b0;

        // seeded random phase
        cur_req = "R9";
        for (int n = 0; n < 4000; n++) begin
            pkt_mode   = ($urandom % 8) == 0;
            ovl_ncq    = ($urandom % 6) != 0;
            ovl_nzo    = ($urandom % 6) != 0;
            if (($urandom % 50) == 0) cap_mask = 16'($urandom);
            if (($urandom % 50) == 0) feat_mask = 16'($urandom) | 16'h0040;
            comreset   = ($urandom % 20) == 0;
            ctl_valid  = ($urandom % 3) == 0;
            ctl_set    = ($urandom % 3) != 0;
            ctl_sel    = 3'($urandom);
            cmd_valid  = ($urandom % 4) == 0;
            cmd_queued = $urandom % 2;
            dma_off_in = $urandom;
            rd_idx     = (($urandom % 4) == 0) ? 8'($urandom) : 8'(74 + $urandom % 7);
            step();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule